// File: doc/BRIEF.md
# Stop-Clock Request Sequencer

This block sits on the system side of a processor bus. It moves the processor into its low-power stop states and brings it back out. When a power manager raises a sleep request, the block drives the active-low stop-clock request pin low. It keeps that pin low until the processor acknowledges the request. The acknowledgement is a stop-grant special bus cycle, which an external decoder flags, closed by the bus ready strobe. The block also waits until posted writes have drained, unless that check is masked.

Once the grant is seen, the block either stays in the granted state or gates the bus clock to reach the deeper stop-clock state. A configuration input selects which. On a wake request from the gated state, the block restarts the clock and counts a programmable settling time so the processor's internal clock generator can lock. Only after that count does it release the request pin, and the processor then resumes execution. A status output reports the current step of the sequence.

Top module: `stpclk_seq`

## Requirements
- R1: While reset is applied, and for two clocks after it is released, `state_o` is 0 (idle), `stpclk_n` is 1 and `clk_gate` is 0.
- R2: A high `sleep_req` sampled in idle moves the block to the request state (`state_o` = 1) on the next clock. `stpclk_n` is 0 in exactly the states 1 to 4.
- R3: The request state lasts at least two clocks and ends only after a grant strobe. The grant strobe is `sg_hit` and `bus_rdy` both high in the same cycle. `wake_req` has no effect in this state.
- R4: Leaving the request state also needs `wb_empty` or `wb_mask` to be high. A grant strobe that arrived earlier is remembered until that condition holds.
- R5: `sg_hit` without `bus_rdy` in the same cycle is not a grant.
- R6: In the granted state (`state_o` = 2) with `gate_en` high, the next clock moves the block to the gated state (`state_o` = 3) and sets `clk_gate` to 1.
- R7: In the granted state with `gate_en` low, the block stays granted with `clk_gate` at 0. A `wake_req` there moves it to release (`state_o` = 5).
- R8: A `wake_req` in the gated state moves the block to settle (`state_o` = 4). Settle lasts `settle_cycles`+1 clocks and is followed by release. With no wake, the gated state holds.
- R9: Release lasts one clock with `stpclk_n` at 1, then the block returns to idle.
- R10: `clk_gate` changes only at a clock edge that ends a cycle spent in the granted or settle state. It drops to 0 after the first settle cycle.
- R11: `sleep_req` has no effect outside the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | Request to enter the stop states |
| wake_req | input | 1 | Request to leave the stop states |
| gate_en | input | 1 | 1: gate the bus clock after the grant |
| settle_cycles | input | CNT_W | Clock-settling wait, in clocks minus one |
| sg_hit | input | 1 | Decoded stop-grant special cycle on the bus |
| bus_rdy | input | 1 | Bus ready strobe, active high |
| wb_empty | input | 1 | Processor write buffers are empty |
| wb_mask | input | 1 | Ignore `wb_empty` |
| stpclk_n | output | 1 | Stop-clock request to the processor, active low |
| clk_gate | output | 1 | 1: bus clock stopped |
| state_o | output | 3 | 0 idle, 1 request, 2 granted, 3 gated, 4 settle, 5 release |

## Verification
The bench targets a grant strobe arriving in the first request cycle. A design without the minimum hold would drop the request after only one clock. It also checks a grant given while writes are still pending, where a design that forgets the strobe would hang in the request state. A decoded stop-grant cycle without the ready strobe must not count as a grant. Two settle counts, including zero, show whether the release point is off by one. A gate output that moves on the wake edge itself, rather than after the first settle cycle, is caught by the per-clock reference model.

// File: rtl/stpclk_pkg.sv
package stpclk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_GRANT   = 3'd2,
    ST_GATED   = 3'd3,
    ST_SETTLE  = 3'd4,
    ST_RELEASE = 3'd5
  } lp_state_e;
endpackage

// File: rtl/stpclk_grant_det.sv
module stpclk_grant_det #(
  parameter int MIN_HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic sg_hit,
  input  logic bus_rdy,
  input  logic wb_empty,
  input  logic wb_mask,
  output logic grant_ok
);
  localparam int AW = (MIN_HOLD > 2) ? $clog2(MIN_HOLD) : 1;
  localparam logic [AW-1:0] AGE_MAX = AW'(MIN_HOLD - 1);

  logic          seen_q, seen_d;
  logic [AW-1:0] age_q, age_d;
  logic          strobe;

  assign strobe = sg_hit & bus_rdy;

  always_comb begin
    seen_d = seen_q;
    age_d  = age_q;
    if (!in_req) begin
      seen_d = 1'b0;
      age_d  = '0;
    end else begin
      if (strobe) seen_d = 1'b1;
      if (age_q != AGE_MAX) age_d = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      age_q  <= '0;
    end else begin
      seen_q <= seen_d;
      age_q  <= age_d;
    end
  end

  assign grant_ok = in_req & (seen_q | strobe) & (wb_empty | wb_mask) & (age_q >= AGE_MAX);
endmodule

// File: rtl/stpclk_settle_tmr.sv
module stpclk_settle_tmr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | (run & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/stpclk_fsm.sv
module stpclk_fsm
  import stpclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      wake_req,
  input  logic      gate_en,
  input  logic      grant_ok,
  input  logic      settle_done,
  output lp_state_e state,
  output logic      load_settle,
  output logic      stpclk_n,
  output logic      clk_gate
);
  lp_state_e state_d;
  logic      gate_d, gate_en_q;
  logic      stp_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:    if (sleep_req) state_d = ST_REQ;
      ST_REQ:     if (grant_ok)  state_d = ST_GRANT;
      ST_GRANT: begin
        if (gate_en)       state_d = ST_GATED;
        else if (wake_req) state_d = ST_RELEASE;
      end
      ST_GATED:   if (wake_req)    state_d = ST_SETTLE;
      ST_SETTLE:  if (settle_done) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign load_settle = (state == ST_GATED) & wake_req;

  always_comb begin
    gate_en_q = 1'b0;
    gate_d    = clk_gate;
    if (state == ST_GRANT && gate_en) begin
      gate_en_q = 1'b1;
      gate_d    = 1'b1;
    end else if (state == ST_SETTLE) begin
      gate_en_q = 1'b1;
      gate_d    = 1'b0;
    end
  end

  assign stp_d = !(state_d == ST_REQ || state_d == ST_GRANT ||
                   state_d == ST_GATED || state_d == ST_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      stpclk_n <= 1'b1;
    end else begin
      state    <= state_d;
      stpclk_n <= stp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         clk_gate <= 1'b0;
    else if (gate_en_q) clk_gate <= gate_d;
  end
endmodule

// File: rtl/stpclk_seq.sv
module stpclk_seq
  import stpclk_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MIN_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             gate_en,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             sg_hit,
  input  logic             bus_rdy,
  input  logic             wb_empty,
  input  logic             wb_mask,
  output logic             stpclk_n,
  output logic             clk_gate,
  output logic [2:0]       state_o
);
  logic      rst_s1, rst_sync;
  lp_state_e state;
  logic      grant_ok, settle_done, load_settle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  stpclk_grant_det #(.MIN_HOLD(MIN_HOLD)) u_grant (
    .clk(clk), .rst_n(rst_sync), .in_req(state == ST_REQ),
    .sg_hit(sg_hit), .bus_rdy(bus_rdy), .wb_empty(wb_empty),
    .wb_mask(wb_mask), .grant_ok(grant_ok)
  );

  stpclk_settle_tmr #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_sync), .load(load_settle),
    .load_val(settle_cycles), .run(state == ST_SETTLE), .done(settle_done)
  );

  stpclk_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync), .sleep_req(sleep_req), .wake_req(wake_req),
    .gate_en(gate_en), .grant_ok(grant_ok), .settle_done(settle_done),
    .state(state), .load_settle(load_settle), .stpclk_n(stpclk_n),
    .clk_gate(clk_gate)
  );

  assign state_o = state;
endmodule

// File: rtl/stpclk_seq_chk.sv
module stpclk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       wake_req,
  input logic [2:0] state_o,
  input logic       stpclk_n,
  input logic       clk_gate
);
  a_r2_enter_request: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && sleep_req && $past(rst_n)) |=> (state_o == 3'd1 && !stpclk_n));

  a_r3_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stpclk_n) |=> !stpclk_n);

  a_r3_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |=> (state_o == 3'd1 || state_o == 3'd2));

  a_r8_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && !wake_req) |=> (state_o == 3'd3 && clk_gate));

  a_r9_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |-> (stpclk_n ##1 state_o == 3'd0));

  a_r10_gate_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_gate) |-> ($past(state_o) == 3'd2 || $past(state_o) == 3'd4));

  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);
endmodule

bind stpclk_seq stpclk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
  .state_o(state_o), .stpclk_n(stpclk_n), .clk_gate(clk_gate)
);

// File: tb/tb_stpclk_seq.sv
`timescale 1ns/1ps
module tb_stpclk_seq;
  localparam int CW = 8;
  logic clk, rst_n, sleep_req, wake_req, gate_en, sg_hit, bus_rdy, wb_empty, wb_mask;
  logic [CW-1:0] settle_cycles;
  logic stpclk_n, clk_gate;
  logic [2:0] state_o;
  int checks = 0, fails = 0, cyc_cnt = 0;
  bit done = 0;

  stpclk_seq #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .gate_en(gate_en), .settle_cycles(settle_cycles), .sg_hit(sg_hit),
    .bus_rdy(bus_rdy), .wb_empty(wb_empty), .wb_mask(wb_mask),
    .stpclk_n(stpclk_n), .clk_gate(clk_gate), .state_o(state_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_state, m_cnt, m_age;
  bit m_seen, m_gate, m_rs1, m_rs2;

  function automatic string st_tag(int s);
    case (s)
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_age = 0; m_seen = 0; m_gate = 0; m_rs1 = 0; m_rs2 = 0;
    end else begin
      if (m_rs2) begin
        automatic int ns = m_state;
        automatic bit hit = sg_hit && bus_rdy;
        if (m_state == 2 && gate_en) m_gate = 1;
        if (m_state == 4) m_gate = 0;
        case (m_state)
          0: if (sleep_req) ns = 1;
          1: if ((m_seen || hit) && (wb_empty || wb_mask) && m_age >= 1) ns = 2;
          2: if (gate_en) ns = 3; else if (wake_req) ns = 5;
          3: if (wake_req) begin ns = 4; m_cnt = settle_cycles; end
          4: if (m_cnt == 0) ns = 5; else m_cnt--;
          default: ns = 0;
        endcase
        if (m_state != 1) begin m_seen = 0; m_age = 0; end
        else begin if (hit) m_seen = 1; m_age = 1; end
        m_state = ns;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
    #2;
    if (rst_n) begin
      chk(state_o == m_state[2:0], st_tag(m_state), state_o, m_state);
      chk(stpclk_n == !(m_state >= 1 && m_state <= 4), "R2", stpclk_n, !(m_state >= 1 && m_state <= 4));
      chk(clk_gate == m_gate, "R10", clk_gate, m_gate);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1; cyc(1); sleep_req = 0;
  endtask

  task automatic pulse_wake();
    wake_req = 1; cyc(1); wake_req = 0;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sleep_req = 0; wake_req = 0; gate_en = 0; sg_hit = 0; bus_rdy = 0;
    wb_empty = 1; wb_mask = 0; settle_cycles = 3;
    cyc(3);
    chk(state_o == 0 && stpclk_n && !clk_gate, "R1", state_o, 0);
    rst_n = 1; cyc(1);
    chk(state_o == 0 && stpclk_n && !clk_gate, "R1", state_o, 0);
    cyc(2);
    // basic sleep without gating
    pulse_sleep();
    chk(state_o == 1 && !stpclk_n, "R2", state_o, 1);
    cyc(2);
    sg_hit = 1; bus_rdy = 1; cyc(1); sg_hit = 0; bus_rdy = 0;
    chk(state_o == 2, "R3", state_o, 2);
    cyc(3);
    chk(state_o == 2 && !clk_gate, "R7", state_o, 2);
    pulse_sleep();
    chk(state_o == 2, "R11", state_o, 2);
    pulse_wake();
    chk(state_o == 5 && stpclk_n, "R9", state_o, 5);
    cyc(1);
    chk(state_o == 0, "R9", state_o, 0);
    // grant in first request cycle: minimum hold
    pulse_sleep();
    sg_hit = 1; bus_rdy = 1; cyc(1); sg_hit = 0; bus_rdy = 0;
    chk(state_o == 1 && !stpclk_n, "R3", state_o, 1);
    cyc(1);
    chk(state_o == 2, "R3", state_o, 2);
    pulse_wake(); cyc(1);
    // decoded cycle without ready, wake during request
    pulse_sleep();
    wake_req = 1; sg_hit = 1; cyc(3); wake_req = 0; sg_hit = 0;
    chk(state_o == 1, "R5", state_o, 1);
    wb_empty = 0;
    sg_hit = 1; bus_rdy = 1; cyc(1); sg_hit = 0; bus_rdy = 0;
    cyc(1);
    chk(state_o == 1, "R4", state_o, 1);
    wb_empty = 1; cyc(1);
    chk(state_o == 2, "R4", state_o, 2);
    pulse_wake(); cyc(1);
    // gated path, masked write-buffer check, settle 3
    gate_en = 1; wb_empty = 0; wb_mask = 1; settle_cycles = 3;
    pulse_sleep();
    sg_hit = 1; bus_rdy = 1; cyc(1); sg_hit = 0; bus_rdy = 0;
    cyc(1);
    chk(state_o == 2, "R4", state_o, 2);
    cyc(1);
    chk(state_o == 3 && clk_gate, "R6", state_o, 3);
    cyc(4);
    chk(state_o == 3 && clk_gate, "R8", state_o, 3);
    pulse_wake();
    chk(state_o == 4 && clk_gate, "R10", clk_gate, 1);
    cyc(1);
    chk(state_o == 4 && !clk_gate, "R10", clk_gate, 0);
    cyc(2);
    chk(state_o == 4, "R8", state_o, 4);
    cyc(1);
    chk(state_o == 5 && stpclk_n, "R8", state_o, 5);
    cyc(1);
    // settle 0
    settle_cycles = 0;
    pulse_sleep();
    sg_hit = 1; bus_rdy = 1; cyc(2); sg_hit = 0; bus_rdy = 0;
    cyc(2);
    chk(state_o == 3, "R6", state_o, 3);
    pulse_wake();
    chk(state_o == 4, "R8", state_o, 4);
    cyc(1);
    chk(state_o == 5 && !clk_gate, "R8", state_o, 5);
    cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule